// File: doc/BRIEF.md
# Global Register Bank Switcher

This block holds the processor-state register of a core together with four shadow banks of eight 64-bit global registers: normal, alternate, MMU and interrupt. The register file sees a single active set of globals. It writes to that set through one write port and reads from it through two read ports. When software writes a new processor-state value, the block masks the value and extracts a sparse three-bit bank-select field. If the field differs from the current one, the block exchanges the active globals with the chosen shadow bank.

The exchange runs as a sequenced copy that moves one register per cycle. First the eight active registers are saved into the bank named by the old select field. Then the bank named by the new field is loaded into the active set. While this runs, the block raises `busy` and accepts neither state writes nor register writes. The requester must hold its state write until `busy` drops. The new processor-state value becomes visible only once the copy has finished.

Top module: `gbank_switch`

## Requirements
- R1: The stored processor-state value is the written value ANDed with 0xF3F, and `st_rd` always shows this masked value.
- R2: The bank-select field is the stored value ANDed with 0xC01. A field of exactly 0x001 selects the alternate bank, 0x400 selects the MMU bank and 0x800 selects the interrupt bank.
- R3: When a state write has the same select field as the current state, `st_rd` takes the masked value one cycle after the write is accepted. In that case `busy` stays low and the active registers are unchanged.
- R4: When a state write has a different select field, `busy` is high for exactly 16 cycles after the accepting clock edge. This is 2 × 8 register copies.
- R5: During a swap, the eight active registers are first saved into the bank selected by the old field. That bank returns them unchanged when it is later selected again.
- R6: After a swap, the active registers hold the contents of the bank selected by the new field. A bank that was never saved into reads as zero.
- R7: While a swap is in progress, `st_rd` keeps the old state. The new state appears in the same cycle that `busy` falls.
- R8: A state write or register write presented while `busy` is high is not accepted. A state write held until `busy` falls is then accepted on the next clock edge.
- R9: Any select field other than 0x001, 0x400 or 0x800 selects the normal bank. This includes 0x000, 0xC01 and 0x401.
- R10: After reset, `st_rd` is 0, `busy` is 0, and every active and banked register is 0.
- R11: `gr_we` with `busy` low writes `gr_wdata` into active register `gr_waddr` on the next edge. `ra_data` and `rb_data` combinationally return the active registers at `ra_addr` and `rb_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_we | input | 1 | Processor-state write request, held while busy |
| st_wdata | input | 12 | Processor-state value to write (masked before storing) |
| st_rd | output | 12 | Current processor-state value |
| busy | output | 1 | Bank swap in progress |
| gr_we | input | 1 | Active global register write enable |
| gr_waddr | input | 3 | Active global register write index |
| gr_wdata | input | 64 | Active global register write data |
| ra_addr | input | 3 | Read port A index |
| ra_data | output | 64 | Read port A data |
| rb_addr | input | 3 | Read port B index |
| rb_data | output | 64 | Read port B data |

## Verification
The assertions assume that the requester obeys the stall rule. A state write or register write raised during a swap is held or retried rather than counted as done, so the pending-state and sequencer properties rely on acceptance only ever happening with `busy` low. The stimulus keeps to this contract. It waits for `busy` to fall before every fresh write. Its one deliberate overlap holds the state write steady across the whole swap and drops the register write it raises during the swap, which is the case the stall rule defines.

// File: rtl/gbank_pkg.sv
package gbank_pkg;
    localparam int          ST_W     = 12;
    localparam int          NBANKS   = 4;
    localparam int          BANK_W   = $clog2(NBANKS);
    localparam logic [11:0] ST_MASK  = 12'hF3F;
    localparam logic [11:0] SEL_MASK = 12'hC01;
    localparam logic [11:0] SEL_ALT  = 12'h001;
    localparam logic [11:0] SEL_MMU  = 12'h400;
    localparam logic [11:0] SEL_INTR = 12'h800;

    typedef enum logic [BANK_W-1:0] {
        BANK_NORM = 2'd0,
        BANK_ALT  = 2'd1,
        BANK_MMU  = 2'd2,
        BANK_INTR = 2'd3
    } bank_e;
endpackage

// File: rtl/gbank_sel_decode.sv
module gbank_sel_decode
    import gbank_pkg::*;
(
    input  logic [ST_W-1:0] st,
    output bank_e           bank
);
    always_comb begin
        unique case (st & SEL_MASK)
            SEL_ALT:  bank = BANK_ALT;
            SEL_MMU:  bank = BANK_MMU;
            SEL_INTR: bank = BANK_INTR;
            default:  bank = BANK_NORM;
        endcase
    end
endmodule

// File: rtl/gbank_swap_seq.sv
module gbank_swap_seq #(
    parameter int NREGS = 8,
    localparam int IW = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          load_phase,
    output logic [IW-1:0] idx,
    output logic          last
);
    localparam logic [IW-1:0] IDX_MAX = IW'(NREGS - 1);

    typedef struct packed {
        logic          busy;
        logic          load;
        logic [IW-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!seq_q.busy) begin
            if (start) begin
                seq_d.busy = 1'b1;
                seq_d.load = 1'b0;
                seq_d.idx  = '0;
            end
        end else if (seq_q.idx == IDX_MAX) begin
            seq_d.idx = '0;
            if (seq_q.load) begin
                seq_d.busy = 1'b0;
                seq_d.load = 1'b0;
            end else begin
                seq_d.load = 1'b1;
            end
        end else begin
            seq_d.idx = seq_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign busy       = seq_q.busy;
    assign load_phase = seq_q.load;
    assign idx        = seq_q.idx;
    assign last       = seq_q.busy && seq_q.load && (seq_q.idx == IDX_MAX);

    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy);
    assert_busy_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy);
    assert_start_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/gbank_switch.sv
module gbank_switch
    import gbank_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int NREGS = 8,
    localparam int IW = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            st_we,
    input  logic [ST_W-1:0] st_wdata,
    output logic [ST_W-1:0] st_rd,
    output logic            busy,
    input  logic            gr_we,
    input  logic [IW-1:0]   gr_waddr,
    input  logic [XLEN-1:0] gr_wdata,
    input  logic [IW-1:0]   ra_addr,
    output logic [XLEN-1:0] ra_data,
    input  logic [IW-1:0]   rb_addr,
    output logic [XLEN-1:0] rb_data
);
    typedef struct packed {
        logic [ST_W-1:0]                           st;
        logic [ST_W-1:0]                           pend;
        logic [BANK_W-1:0]                         old_b;
        logic [BANK_W-1:0]                         new_b;
        logic [NREGS-1:0][XLEN-1:0]                act;
        logic [NBANKS-1:0][NREGS-1:0][XLEN-1:0]    banks;
    } core_t;

    core_t core_d, core_q;

    logic            seq_busy, seq_load, seq_last, swap_req, accept;
    logic [IW-1:0]   seq_idx;
    logic [ST_W-1:0] masked;
    bank_e           cur_bank, nxt_bank;

    assign masked = st_wdata & ST_MASK;
    assign accept = st_we && !seq_busy;
    assign swap_req = accept && ((masked & SEL_MASK) != (core_q.st & SEL_MASK));

    gbank_sel_decode u_dec_cur (.st(core_q.st), .bank(cur_bank));
    gbank_sel_decode u_dec_nxt (.st(masked),    .bank(nxt_bank));

    gbank_swap_seq #(.NREGS(NREGS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (swap_req),
        .busy       (seq_busy),
        .load_phase (seq_load),
        .idx        (seq_idx),
        .last       (seq_last)
    );

    always_comb begin
        core_d = core_q;
        if (accept && !swap_req) core_d.st = masked;
        if (swap_req) begin
            core_d.pend  = masked;
            core_d.old_b = cur_bank;
            core_d.new_b = nxt_bank;
        end
        if (gr_we && !seq_busy) core_d.act[gr_waddr] = gr_wdata;
        if (seq_busy) begin
            if (!seq_load) core_d.banks[core_q.old_b][seq_idx] = core_q.act[seq_idx];
            else           core_d.act[seq_idx] = core_q.banks[core_q.new_b][seq_idx];
        end
        if (seq_last) core_d.st = core_q.pend;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign st_rd   = core_q.st;
    assign busy    = seq_busy;
    assign ra_data = core_q.act[ra_addr];
    assign rb_data = core_q.act[rb_addr];

    assert_state_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_rd & ~ST_MASK) == '0);
    assert_same_sel_no_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_we && !busy && ((st_wdata & SEL_MASK) == (st_rd & SEL_MASK))) |=> !busy);
    assert_state_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seq_last) |=> $stable(st_rd));
    assert_commit_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (st_rd == $past(core_q.pend)));
    assert_pend_stalled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(core_q.pend));
endmodule

// File: tb/gbank_switch_tb.sv
`timescale 1ns/1ps
module gbank_switch_tb;
    localparam int XLEN = 64;
    localparam int NREGS = 8;
    localparam int IW = 3;
    localparam int NVEC = 11;
    // each entry: {state value 12 bits, register fill tag 8 bits}
    localparam logic [19:0] VEC [NVEC] = '{
        20'h001A1, 20'h0FFA2, 20'h400A3, 20'hFFFA4, 20'h800A5, 20'h000A6,
        20'h001A7, 20'h401A8, 20'h400A9, 20'hC00AA, 20'h000AB
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic            rst_n, st_we, busy, gr_we;
    logic [11:0]     st_wdata, st_rd;
    logic [IW-1:0]   gr_waddr, ra_addr, rb_addr;
    logic [XLEN-1:0] gr_wdata, ra_data, rb_data;

    gbank_switch #(.XLEN(XLEN), .NREGS(NREGS)) u_dut (
        .clk(clk), .rst_n(rst_n), .st_we(st_we), .st_wdata(st_wdata), .st_rd(st_rd),
        .busy(busy), .gr_we(gr_we), .gr_waddr(gr_waddr), .gr_wdata(gr_wdata),
        .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [XLEN-1:0] m_act [NREGS];
    logic [XLEN-1:0] m_bank [4][NREGS];
    logic [11:0] m_st;

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int bsel(logic [11:0] s);
        case (s & 12'hC01)
            12'h001: return 1;
            12'h400: return 2;
            12'h800: return 3;
            default: return 0;
        endcase
    endfunction

    task automatic fill(logic [7:0] tag);
        for (int i = 0; i < NREGS; i++) begin
            @(negedge clk);
            gr_we = 1'b1; gr_waddr = IW'(i);
            gr_wdata = {tag, 8'(i), 48'h5A5A_0000_1234};
            m_act[i] = gr_wdata;
        end
        @(negedge clk);
        gr_we = 1'b0;
    endtask

    task automatic check_regs(string req);
        bit ok = 1;
        logic [63:0] a = '0, e = '0;
        for (int i = 0; i < NREGS; i++) begin
            ra_addr = IW'(i); rb_addr = IW'(NREGS - 1 - i);
            #0.1;
            if (ra_data !== m_act[i]) begin ok = 0; a = ra_data; e = m_act[i]; end
            if (rb_data !== m_act[NREGS-1-i]) begin ok = 0; a = rb_data; e = m_act[NREGS-1-i]; end
        end
        chk(ok, req, a, e);
    endtask

    task automatic model_swap(logic [11:0] nst);
        if ((nst & 12'hC01) != (m_st & 12'hC01)) begin
            for (int i = 0; i < NREGS; i++) m_bank[bsel(m_st)][i] = m_act[i];
            for (int i = 0; i < NREGS; i++) m_act[i] = m_bank[bsel(nst)][i];
        end
        m_st = nst;
    endtask

    task automatic st_write(logic [11:0] w);
        logic [11:0] nst = w & 12'hF3F;
        bit swap = (nst & 12'hC01) != (m_st & 12'hC01);
        int cyc = 0;
        @(negedge clk);
        st_we = 1'b1; st_wdata = w;
        @(negedge clk);
        st_we = 1'b0;
        while (busy && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
        model_swap(nst);
        if (swap) chk(cyc == 16, "R4 swap length", 64'(cyc), 64'd16);
        else      chk(cyc == 0, "R3 no swap on same field", 64'(cyc), 64'd0);
        chk(st_rd == m_st, "R1 R7 masked state", 64'(st_rd), 64'(m_st));
        check_regs(swap ? "R2 R5 R6 R9 bank contents" : "R3 R11 regs unchanged");
    endtask

    initial begin
        #(4ns * 150000);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; st_we = 1'b0; st_wdata = '0; gr_we = 1'b0;
        gr_waddr = '0; gr_wdata = '0; ra_addr = '0; rb_addr = '0;
        m_st = '0;
        for (int b = 0; b < 4; b++) for (int i = 0; i < NREGS; i++) m_bank[b][i] = '0;
        for (int i = 0; i < NREGS; i++) m_act[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(st_rd == 12'h000, "R10 reset state", 64'(st_rd), 64'h0);
        chk(busy == 1'b0, "R10 reset busy", 64'(busy), 64'h0);
        check_regs("R10 reset regs");

        // table walk: fill active set, write state, compare with model
        for (int v = 0; v < NVEC; v++) begin
            fill(VEC[v][7:0]);
            check_regs("R11 write and read ports");
            st_write(VEC[v][19:8]);
        end

        // stall: state write held and register write dropped during a swap (R7, R8)
        fill(8'hE0);
        @(negedge clk);
        st_we = 1'b1; st_wdata = 12'h800;
        @(negedge clk);
        chk(busy == 1'b1, "R4 busy after accept", 64'(busy), 64'h1);
        st_wdata = 12'h820;
        gr_we = 1'b1; gr_waddr = 3'd2; gr_wdata = 64'hDEAD_BEEF_DEAD_BEEF;
        @(negedge clk);
        gr_we = 1'b0;
        chk(st_rd == m_st, "R7 old state during swap", 64'(st_rd), 64'(m_st));
        while (busy) @(negedge clk);
        model_swap(12'h800);
        chk(st_rd == 12'h800, "R7 new state on busy fall", 64'(st_rd), 64'h800);
        @(negedge clk);
        st_we = 1'b0;
        model_swap(12'h820);
        chk(st_rd == 12'h820, "R8 held write accepted after busy", 64'(st_rd), 64'h820);
        chk(busy == 1'b0, "R3 held same-field write no swap", 64'(busy), 64'h0);
        check_regs("R8 register write during busy dropped");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule